// File: doc/BRIEF.md
# Pipelined Fixed-Point Reciprocal Square Root

This unit computes 1/sqrt(x) for an unsigned fixed-point operand with 16 bits, 8 of them fractional. It accepts one operand on every clock cycle for which `validIn` is high and never stalls. Each result leaves the unit exactly 17 cycles later, marked by `validOut`. No handshake or backpressure is involved: the valid flag travels down a shift line of the same length as the arithmetic.

The arithmetic has four parts. The first part counts the leading zeros of the operand and shifts it left by an even amount, which places the mantissa in [0.25, 1). The second part seeds an estimate from a quadratic polynomial in that mantissa. Three Newton-Raphson steps then refine the estimate, each computing y' = y*(3 - m*y*y)/2 over three registered multiply stages on words wider than the port. A last stage shifts the refined value right by an amount set by half of the normalisation shift, rounds it to the nearest output step, and saturates it. Delay registers pad the path to the fixed latency.

The unit sits in a streaming datapath, for example vector normalisation. There, a producer can issue samples back to back or with gaps, and the consumer simply qualifies `dataOut` with `validOut`.

Top module: `rsqrt_pipe`

## Requirements
- R1: For every nonzero input code c (value c/256), the output code differs from the ideal value 4096/sqrt(c) by at most 1.0 code, that is 2^-8 in output units. The output has the same unsigned format as the input: 8 integer bits and 8 fractional bits.
- R2: A sample taken with `validIn`=1 at a rising edge produces `validOut`=1, with its result on `dataOut`, when observed after the 17th rising edge counted from and including that one.
- R3: `validOut` follows `validIn` delayed by 17 cycles, bubbles included. Back-to-back inputs give back-to-back outputs at one result per cycle.
- R4: An input code of 0x0000 returns 0xFFFF, and `validOut` still rises on schedule.
- R5: Reset is synchronous. While it is sampled high, every stage of the valid line clears, so `validOut` is 0 in the following cycle. Samples in flight, or presented while reset is high, never produce `validOut`.
- R6: `dataOut` keeps its previous value in every cycle where `validOut` is 0, across gaps and across reset.
- R7: For a nonzero input, the output never exceeds 0x1000 (16.0). Input code 0x0001 gives exactly that value.
- R8: When the ideal result is a whole number of output codes, the output equals it exactly. Examples: 0x0100 gives 0x0100, 0x0400 gives 0x0080, 0x0040 gives 0x0200, 0x4000 gives 0x0020, 0x0004 gives 0x0800, and 0x0010 gives 0x0400.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the valid line |
| validIn | input | 1 | Qualifies `dataIn` in this cycle |
| dataIn | input | 16 | Unsigned operand, 8 fractional bits |
| validOut | output | 1 | `dataOut` holds a result in this cycle |
| dataOut | output | 16 | Unsigned 1/sqrt result, 8 fractional bits |

## Verification
The bound checker watches the timing and framing rules on every cycle. It checks the 17-cycle valid delay against its own shadow line, the clearing effect of reset, the saturated result for a zero operand, the upper bound for nonzero operands, and that the output holds while no result is valid. Numerical accuracy across the operand range cannot be expressed cycle by cycle without a reference model, so only the bench shows it. The same goes for exact rounding at results that are whole codes, and for samples discarded by a reset in mid-stream. The bench covers these with a full 0.1-step sweep, random gapped traffic and directed corner codes.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;
  // port format
  localparam int DATA_W       = 16;
  localparam int FRAC_W       = 8;
  // internal estimate precision and refinement depth
  localparam int EST_FRAC     = 24;
  localparam int NEWTON_ITERS = 3;
  localparam int LATENCY      = 17;

  localparam int LZ_W = $clog2(DATA_W + 1);
  localparam int YW   = EST_FRAC + 2;   // estimate, 2 integer bits
  localparam int YYW  = YW + 2;         // square of estimate, 4 integer bits
  localparam int SW   = EST_FRAC + 4;   // signed polynomial words

  // stage indices along the pipe
  localparam int S_LZ     = 0;
  localparam int S_SHIFT  = 1;
  localparam int S_POLY1  = 2;
  localparam int S_POLY2  = 3;
  localparam int S_NEWT0  = 4;
  localparam int S_ROUND  = S_NEWT0 + 3 * NEWTON_ITERS;
  localparam int CORE_LEN = S_ROUND + 1;

  // right shift applied to the estimate when half the normalisation shift is zero
  localparam int OUT_BASE = EST_FRAC - FRAC_W + (DATA_W - FRAC_W) / 2;

  typedef struct packed {
    logic [DATA_W-1:0] mant;
    logic [LZ_W-1:0]   halfShift;
    logic              isZero;
  } sideBand_t;

  typedef struct packed {
    logic [LATENCY-1:0] stageEn;
  } pipeStrobe_t;
endpackage

// File: rtl/rsqrt_ctrl.sv
module rsqrt_ctrl
  import rsqrt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        validIn,
  output pipeStrobe_t strobe,
  output logic        validOut
);
  logic [LATENCY-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[LATENCY-2:0], validIn};
  end

  // stage i loads only when the word entering it is valid; reset freezes data
  assign strobe.stageEn = {vPipe[LATENCY-2:0], validIn} & {LATENCY{!rst}};
  assign validOut       = vPipe[LATENCY-1];
endmodule

// File: rtl/rsqrt_datapath.sv
module rsqrt_datapath
  import rsqrt_pkg::*;
(
  input  logic              clk,
  input  pipeStrobe_t       strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam real SCALE = 2.0 ** EST_FRAC;
  // quadratic seed a + b*m + c*m^2 through m = 0.25, 0.5, 1
  localparam logic signed [SW-1:0] SEED_A = SW'($rtoi( 2.83823955 * SCALE));
  localparam logic signed [SW-1:0] SEED_B = SW'($rtoi(-3.85786438 * SCALE));
  localparam logic signed [SW-1:0] SEED_C = SW'($rtoi( 2.01962485 * SCALE));
  localparam logic [YYW-1:0]       THREE  = YYW'(3) << EST_FRAC;
  localparam int PW = SW + DATA_W + 1;

  function automatic logic [LZ_W-1:0] countLead(input logic [DATA_W-1:0] v);
    countLead = LZ_W'(DATA_W);
    for (int b = 0; b < DATA_W; b++)
      if (v[b]) countLead = LZ_W'(DATA_W - 1 - b);
  endfunction

  logic [DATA_W-1:0]     c0;
  logic [LZ_W-1:0]       lz0;
  logic [LZ_W-1:0]       shiftEven;
  logic signed [SW-1:0]  uQ;
  sideBand_t             sideQ [S_SHIFT:S_ROUND-1];
  logic [YW-1:0]         yQ    [S_POLY2:S_ROUND-1];
  logic [YYW-1:0]        yyQ   [NEWTON_ITERS];
  logic [YYW-1:0]        tQ    [NEWTON_ITERS];
  logic [DATA_W-1:0]     outQ  [S_ROUND:LATENCY-1];
  logic [DATA_W-1:0]     roundVal;

  // normalise: leading-zero count, then even left shift
  assign shiftEven = lz0 & ~LZ_W'(1);

  always_ff @(posedge clk) begin
    if (strobe.stageEn[S_LZ]) begin
      c0  <= dataIn;
      lz0 <= countLead(dataIn);
    end
    if (strobe.stageEn[S_SHIFT])
      sideQ[S_SHIFT] <= '{mant: c0 << shiftEven, halfShift: shiftEven >> 1,
                          isZero: (c0 == '0)};
    if (strobe.stageEn[S_POLY1])
      uQ <= SEED_B + SW'((PW'(SEED_C) *
                          PW'($signed({1'b0, sideQ[S_SHIFT].mant}))) >>> DATA_W);
    if (strobe.stageEn[S_POLY2])
      yQ[S_POLY2] <= YW'(SEED_A + SW'((PW'($signed({1'b0, sideQ[S_POLY1].mant})) *
                                        PW'(uQ)) >>> DATA_W));
  end

  // side information travels with the estimate
  for (genvar i = S_POLY1; i < S_ROUND; i++) begin : g_side
    always_ff @(posedge clk)
      if (strobe.stageEn[i]) sideQ[i] <= sideQ[i-1];
  end

  // Newton steps: y*y, then m*y*y, then y*(3 - t)/2
  for (genvar j = 0; j < NEWTON_ITERS; j++) begin : g_newton
    localparam int SA = S_NEWT0 + 3 * j;
    always_ff @(posedge clk) begin
      if (strobe.stageEn[SA]) begin
        yyQ[j] <= YYW'(((2*YW)'(yQ[SA-1]) * (2*YW)'(yQ[SA-1])) >> EST_FRAC);
        yQ[SA] <= yQ[SA-1];
      end
      if (strobe.stageEn[SA+1]) begin
        tQ[j]    <= YYW'(((DATA_W+YYW)'(sideQ[SA].mant) * (DATA_W+YYW)'(yyQ[j])) >> DATA_W);
        yQ[SA+1] <= yQ[SA];
      end
      if (strobe.stageEn[SA+2])
        yQ[SA+2] <= YW'(((YW+YYW)'(yQ[SA+1]) * (YW+YYW)'(THREE - tQ[j])) >> (EST_FRAC + 1));
    end
  end

  // denormalise, round to nearest, saturate
  always_comb begin
    int          sh;
    logic [YW:0] rnd;
    sh  = OUT_BASE - int'(sideQ[S_ROUND-1].halfShift);
    rnd = ({1'b0, yQ[S_ROUND-1]} + ((YW+1)'(1) << (sh - 1))) >> sh;
    if (sideQ[S_ROUND-1].isZero || (|rnd[YW:DATA_W])) roundVal = '1;
    else                                             roundVal = rnd[DATA_W-1:0];
  end

  always_ff @(posedge clk)
    if (strobe.stageEn[S_ROUND]) outQ[S_ROUND] <= roundVal;

  for (genvar p = S_ROUND + 1; p < LATENCY; p++) begin : g_pad
    always_ff @(posedge clk)
      if (strobe.stageEn[p]) outQ[p] <= outQ[p-1];
  end

  assign dataOut = outQ[LATENCY-1];
endmodule

// File: rtl/rsqrt_pipe.sv
module rsqrt_pipe
  import rsqrt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              validIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              validOut,
  output logic [DATA_W-1:0] dataOut
);
  pipeStrobe_t strobe;

  rsqrt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  rsqrt_datapath u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );
endmodule

// File: rtl/rsqrt_pipe_checker.sv
module rsqrt_pipe_checker
  import rsqrt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              validIn,
  input logic [DATA_W-1:0] dataIn,
  input logic              validOut,
  input logic [DATA_W-1:0] dataOut
);
  localparam logic [DATA_W-1:0] MAX_OUT = DATA_W'(1) << (FRAC_W + (DATA_W - FRAC_W) / 2);

  // independent shadow of what should emerge, one bit per cycle of delay
  logic [LATENCY-1:0] vShadow;
  logic [LATENCY-1:0] zShadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      vShadow <= '0;
      zShadow <= '0;
    end else begin
      vShadow <= {vShadow[LATENCY-2:0], validIn};
      zShadow <= {zShadow[LATENCY-2:0], validIn && (dataIn == '0)};
    end
  end

  assert_valid_delay_R3: assert property (@(posedge clk) disable iff (rst)
    validOut == vShadow[LATENCY-1]);

  assert_reset_clears_R5: assert property (@(posedge clk)
    rst |=> !validOut);

  assert_zero_saturates_R4: assert property (@(posedge clk) disable iff (rst)
    (validOut && zShadow[LATENCY-1]) |-> (dataOut == '1));

  assert_result_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (validOut && !zShadow[LATENCY-1]) |-> (dataOut <= MAX_OUT));

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> $stable(dataOut));
endmodule

bind rsqrt_pipe rsqrt_pipe_checker chk (
  .clk      (clk),
  .rst      (rst),
  .validIn  (validIn),
  .dataIn   (dataIn),
  .validOut (validOut),
  .dataOut  (dataOut)
);

// File: tb/rsqrt_pipe_test.sv
module rsqrt_pipe_test;
  localparam int LAT  = 17;
  localparam int RING = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        validIn = 1'b0;
  logic [15:0] dataIn = '0;
  logic        validOut;
  logic [15:0] dataOut;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lastRst = -1;
  bit done   = 1'b0;
  bit havePrev = 1'b0;
  logic [15:0] prevOut;
  logic        histV [RING];
  logic [15:0] histD [RING];

  rsqrt_pipe uut (
    .clk(clk), .rst(rst), .validIn(validIn), .dataIn(dataIn),
    .validOut(validOut), .dataOut(dataOut)
  );

  always #5 clk = ~clk;

  function automatic real idealCode(input logic [15:0] c);
    return 4096.0 / $sqrt(real'(c));
  endfunction

  task automatic fail(input string tag, input int act, input int exp, input logic [15:0] code);
    fails++;
    $display("FAIL %s cycle %0d input 0x%04h actual 0x%04h expected 0x%04h",
             tag, cyc, code, act, exp);
  endtask

  // compare outputs seen at negedge cyc with the sample driven at cyc-LAT
  task automatic checkOutputs();
    int   j;
    logic expV, rawV, killed;
    logic [15:0] code;
    real  r, err;
    string tag;
    j      = cyc - LAT;
    rawV   = (j >= 0) ? histV[j % RING] : 1'b0;
    code   = (j >= 0) ? histD[j % RING] : 16'h0;
    killed = rawV && (lastRst >= j);
    expV   = rawV && !killed;
    tag    = killed ? "R5" : (expV ? "R2" : "R3");
    checks++;
    if (validOut !== expV) fail(tag, int'(validOut), int'(expV), code);
    if (expV && validOut === 1'b1) begin
      checks++;
      if (code == 16'h0) begin
        if (dataOut !== 16'hFFFF) fail("R4", int'(dataOut), 'hFFFF, code);
      end else begin
        r = idealCode(code);
        if (r == $floor(r)) begin
          if (int'(dataOut) != $rtoi(r)) fail("R8", int'(dataOut), $rtoi(r), code);
        end else begin
          err = real'(dataOut) - r;
          if (err < 0.0) err = -err;
          if (err > 1.0) fail("R1", int'(dataOut), $rtoi(r + 0.5), code);
        end
        checks++;
        if (dataOut > 16'h1000) fail("R7", int'(dataOut), 'h1000, code);
      end
    end else if (!validOut && havePrev) begin
      checks++;
      if (dataOut !== prevOut) fail("R6", int'(dataOut), int'(prevOut), code);
    end
    prevOut  = dataOut;
    havePrev = 1'b1;
  endtask

  task automatic step(input logic r, input logic v, input logic [15:0] d);
    @(negedge clk);
    checkOutputs();
    rst     = r;
    validIn = v;
    dataIn  = d;
    histV[cyc % RING] = v;
    histD[cyc % RING] = d;
    if (r) lastRst = cyc;
    cyc++;
  endtask

  function automatic logic [15:0] randCode();
    logic [15:0] w;
    w = 16'($urandom);
    if (($urandom % 4) == 0) w = w & 16'h000F;
    return w;
  endfunction

  logic [15:0] corner [15] = '{16'h0000, 16'h0001, 16'h0100, 16'h0400, 16'h0040,
                               16'h4000, 16'hFFFF, 16'h0002, 16'h0003, 16'h8000,
                               16'h0019, 16'h0000, 16'h7FFF, 16'h0004, 16'h0010};

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < RING; i++) begin histV[i] = 1'b0; histD[i] = '0; end
    // R5: inputs offered during reset are dropped
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, randCode());
    // R4, R7, R8 directed corners, back to back
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1, corner[i]);
    // R6: idle gap after a burst
    for (int i = 0; i < 24; i++) step(1'b0, 1'b0, 16'($urandom));
    // R1, R3: 0.1 to 100.0 sweep at full rate
    for (int n = 1; n <= 1000; n++) step(1'b0, 1'b1, 16'($rtoi(real'(n) * 25.6 + 0.5)));
    // R1, R3, R6: random gapped traffic
    for (int i = 0; i < 3000; i++) step(1'b0, (($urandom % 10) < 7), randCode());
    // R5: reset while the pipe is full
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, randCode());
    for (int i = 0; i < 3; i++)  step(1'b1, 1'b1, randCode());
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, randCode());
    for (int i = 0; i < 25; i++) step(1'b0, 1'b0, 16'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule